// File: doc/BRIEF.md
# Flash Sector Protection Lock Controller

This block holds the protection and lock state behind a flash memory's command interface. It keeps a copy of a non-volatile mode bit that chooses between password protection and persistent protection. It also keeps a volatile lock bit that decides whether the per-sector protection bits may be rewritten. It keeps a one-time bit that write-protects the secured sector, and it tracks whether the secured sector is currently mapped in. Separately, it follows whether a program or an erase is suspended.

A command decoder sits in front of the block and supplies one-cycle command strobes. A password comparator supplies a match flag. The block answers with permits: protection-bit writes, secured-sector programming, and grant or reject pulses for resume commands. For a chip erase it produces a one-cycle go pulse together with a per-sector mask. The two non-volatile bits are loaded from storage inputs at power-on. They can be set later by command, but they can never be cleared.

Top module: `fsp_lock_ctrl`

## Requirements
- R1: With the password-mode bit set, the lock bit reads 1 in the cycle after a power-on reset or a hardware reset.
- R2: In password mode, the only way to clear the lock bit is a password unlock with the match flag high. After that, the protection-bit write permit is 1.
- R3: In password mode, a lock-set command sets the lock bit back to 1 in the next cycle.
- R4: With the password-mode bit clear (persistent mode), the lock bit reads 0 after a power-on or hardware reset. A lock-set command sets it.
- R5: In persistent mode, a password unlock has no effect. The lock bit keeps its value and no error pulse is raised, whatever the match flag.
- R6: Once the secured-sector protection bit is 1, it stays 1 through hardware resets, and the secured-sector program permit stays 0.
- R7: A chip erase yields a one-cycle erase_go with erase_mask in the next cycle. Bit i of the mask enables sector i. Outside secured-sector mode every bit is 1. In secured-sector mode the erase is still accepted, and exactly one boot sector bit is 0.
- R8: Secured-sector entry is accepted while a program or erase is suspended. A resume issued while the secured sector is enabled pulses resume_reject and keeps the suspension. After exit, a resume pulses resume_grant.
- R9: While supply_low is 1, no command has any effect, secured-sector mode and suspension are cleared, and the protection-bit write permit is 0.
- R10: In password mode, a password unlock with the match flag low leaves the lock bit unchanged and raises unlock_err for exactly one cycle.
- R11: boot_top=1 excludes sector 0 from a secured-mode chip erase. boot_top=0 excludes sector 45, the last of the 46 sectors.
- R12: Power-on and hardware resets are synchronous, active-high, and override any command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| por_rst | input | 1 | Power-on reset, reloads non-volatile copies |
| hw_rst | input | 1 | Hardware reset |
| supply_low | input | 1 | Supply below write-lockout level |
| nv_pwd_mode_i | input | 1 | Stored password-mode bit, loaded at power-on |
| nv_sec_prot_i | input | 1 | Stored secured-sector protection bit, loaded at power-on |
| boot_top | input | 1 | 1 = top boot configuration, 0 = bottom |
| cmd_pwd_mode_set | input | 1 | Set the password-mode bit |
| cmd_sec_prot_set | input | 1 | Set the secured-sector protection bit |
| cmd_lock_set | input | 1 | Set the lock bit |
| cmd_pwd_unlock | input | 1 | Password unlock command |
| pwd_match | input | 1 | Password compare result for the unlock |
| cmd_sec_entry | input | 1 | Enter secured-sector mode |
| cmd_sec_exit | input | 1 | Exit secured-sector mode |
| cmd_pgm_suspend | input | 1 | Program suspended |
| cmd_ers_suspend | input | 1 | Erase suspended |
| cmd_resume | input | 1 | Program/erase resume command |
| cmd_chip_erase | input | 1 | Chip erase command |
| pwd_mode | output | 1 | Current password-mode bit |
| lock_bit | output | 1 | Volatile lock bit |
| ppb_wr_ok | output | 1 | Protection-bit write permit |
| unlock_err | output | 1 | Failed-unlock pulse |
| sec_prot | output | 1 | Secured-sector protection bit |
| sec_mode | output | 1 | Secured sector enabled |
| sec_prog_ok | output | 1 | Secured-sector program permit |
| resume_grant | output | 1 | Resume accepted pulse |
| resume_reject | output | 1 | Resume refused pulse |
| erase_go | output | 1 | Chip erase start pulse |
| erase_mask | output | 46 | Per-sector erase enable |

## Verification
Unlock commands are applied in both modes and with both match values. A clear in password mode with a match tells the two modes apart, and an error with no clear identifies a mismatch. Reset and unlock are applied in the same cycle to show that reset wins. Chip erase is issued outside and inside secured-sector mode under each boot setting, so that an all-ones mask and each single excluded sector can be distinguished. Resume is issued inside and outside secured-sector mode. A burst of commands under supply_low is then checked to have changed nothing.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    localparam int FSP_NUM_SECT = 46;

    typedef enum logic [1:0] {
        SUSP_NONE = 2'd0,
        SUSP_PGM  = 2'd1,
        SUSP_ERS  = 2'd2
    } susp_e;

    typedef struct packed {
        logic mode;
        logic prot;
        logic grant;
        logic reject;
    } sec_stat_t;

    typedef struct packed {
        logic pwd;
        logic lock;
        logic err;
    } lock_stat_t;

    // index of the sector kept out of a secured-mode chip erase
    function automatic int excl_index(input logic top, input int nsect);
        return top ? 0 : nsect - 1;
    endfunction

endpackage

// File: rtl/fsp_lock_unit.sv
module fsp_lock_unit
    import fsp_pkg::*;
(
    input  logic       clk,
    input  logic       por_rst,
    input  logic       hw_rst,
    input  logic       supply_low,
    input  logic       nv_pwd_mode_i,
    input  logic       cmd_pwd_mode_set,
    input  logic       cmd_lock_set,
    input  logic       cmd_pwd_unlock,
    input  logic       pwd_match,
    output lock_stat_t stat
);
    logic pwd_q, lock_q, err_q;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            pwd_q  <= nv_pwd_mode_i;
            lock_q <= nv_pwd_mode_i;
            err_q  <= 1'b0;
        end else if (hw_rst) begin
            lock_q <= pwd_q;
            err_q  <= 1'b0;
        end else if (supply_low) begin
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (cmd_pwd_mode_set)
                pwd_q <= 1'b1;
            if (cmd_lock_set) begin
                lock_q <= 1'b1;
            end else if (cmd_pwd_unlock && pwd_q) begin
                if (pwd_match)
                    lock_q <= 1'b0;
                else
                    err_q <= 1'b1;
            end
        end
    end

    assign stat.pwd  = pwd_q;
    assign stat.lock = lock_q;
    assign stat.err  = err_q;
endmodule

// File: rtl/fsp_sec_unit.sv
module fsp_sec_unit
    import fsp_pkg::*;
(
    input  logic      clk,
    input  logic      por_rst,
    input  logic      hw_rst,
    input  logic      supply_low,
    input  logic      nv_sec_prot_i,
    input  logic      cmd_sec_prot_set,
    input  logic      cmd_sec_entry,
    input  logic      cmd_sec_exit,
    input  logic      cmd_pgm_suspend,
    input  logic      cmd_ers_suspend,
    input  logic      cmd_resume,
    output sec_stat_t stat
);
    logic  prot_q, mode_q, grant_q, reject_q;
    susp_e susp_q;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            prot_q   <= nv_sec_prot_i;
            mode_q   <= 1'b0;
            susp_q   <= SUSP_NONE;
            grant_q  <= 1'b0;
            reject_q <= 1'b0;
        end else if (hw_rst || supply_low) begin
            mode_q   <= 1'b0;
            susp_q   <= SUSP_NONE;
            grant_q  <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            grant_q  <= 1'b0;
            reject_q <= 1'b0;
            if (cmd_sec_prot_set)
                prot_q <= 1'b1;
            if (cmd_sec_exit)
                mode_q <= 1'b0;
            else if (cmd_sec_entry)
                mode_q <= 1'b1;
            if (susp_q == SUSP_NONE) begin
                if (cmd_pgm_suspend)
                    susp_q <= SUSP_PGM;
                else if (cmd_ers_suspend)
                    susp_q <= SUSP_ERS;
            end else if (cmd_resume) begin
                if (mode_q) begin
                    reject_q <= 1'b1;
                end else begin
                    grant_q <= 1'b1;
                    susp_q  <= SUSP_NONE;
                end
            end
        end
    end

    assign stat.mode   = mode_q;
    assign stat.prot   = prot_q;
    assign stat.grant  = grant_q;
    assign stat.reject = reject_q;
endmodule

// File: rtl/fsp_erase_unit.sv
module fsp_erase_unit
    import fsp_pkg::*;
#(
    parameter int NUM_SECT = FSP_NUM_SECT
) (
    input  logic                clk,
    input  logic                por_rst,
    input  logic                hw_rst,
    input  logic                supply_low,
    input  logic                boot_top,
    input  logic                sec_mode,
    input  logic                cmd_chip_erase,
    output logic                erase_go,
    output logic [NUM_SECT-1:0] erase_mask
);
    localparam int TOP_IDX = 0;
    localparam int BOT_IDX = NUM_SECT - 1;

    logic [NUM_SECT-1:0] mask_next;

    for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
        if (i == TOP_IDX && i == BOT_IDX) begin : g_both
            assign mask_next[i] = !sec_mode;
        end else if (i == TOP_IDX) begin : g_top
            assign mask_next[i] = !(sec_mode && boot_top);
        end else if (i == BOT_IDX) begin : g_bot
            assign mask_next[i] = !(sec_mode && !boot_top);
        end else begin : g_mid
            assign mask_next[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (por_rst || hw_rst || supply_low) begin
            erase_go   <= 1'b0;
            erase_mask <= '0;
        end else begin
            erase_go   <= cmd_chip_erase;
            erase_mask <= cmd_chip_erase ? mask_next : '0;
        end
    end
endmodule

// File: rtl/fsp_lock_ctrl.sv
module fsp_lock_ctrl
    import fsp_pkg::*;
#(
    parameter int NUM_SECT = FSP_NUM_SECT
) (
    input  logic                clk,
    input  logic                por_rst,
    input  logic                hw_rst,
    input  logic                supply_low,
    input  logic                nv_pwd_mode_i,
    input  logic                nv_sec_prot_i,
    input  logic                boot_top,
    input  logic                cmd_pwd_mode_set,
    input  logic                cmd_sec_prot_set,
    input  logic                cmd_lock_set,
    input  logic                cmd_pwd_unlock,
    input  logic                pwd_match,
    input  logic                cmd_sec_entry,
    input  logic                cmd_sec_exit,
    input  logic                cmd_pgm_suspend,
    input  logic                cmd_ers_suspend,
    input  logic                cmd_resume,
    input  logic                cmd_chip_erase,
    output logic                pwd_mode,
    output logic                lock_bit,
    output logic                ppb_wr_ok,
    output logic                unlock_err,
    output logic                sec_prot,
    output logic                sec_mode,
    output logic                sec_prog_ok,
    output logic                resume_grant,
    output logic                resume_reject,
    output logic                erase_go,
    output logic [NUM_SECT-1:0] erase_mask
);
    lock_stat_t lk;
    sec_stat_t  sc;

    fsp_lock_unit u_lock (
        .clk              (clk),
        .por_rst          (por_rst),
        .hw_rst           (hw_rst),
        .supply_low       (supply_low),
        .nv_pwd_mode_i    (nv_pwd_mode_i),
        .cmd_pwd_mode_set (cmd_pwd_mode_set),
        .cmd_lock_set     (cmd_lock_set),
        .cmd_pwd_unlock   (cmd_pwd_unlock),
        .pwd_match        (pwd_match),
        .stat             (lk)
    );

    fsp_sec_unit u_sec (
        .clk              (clk),
        .por_rst          (por_rst),
        .hw_rst           (hw_rst),
        .supply_low       (supply_low),
        .nv_sec_prot_i    (nv_sec_prot_i),
        .cmd_sec_prot_set (cmd_sec_prot_set),
        .cmd_sec_entry    (cmd_sec_entry),
        .cmd_sec_exit     (cmd_sec_exit),
        .cmd_pgm_suspend  (cmd_pgm_suspend),
        .cmd_ers_suspend  (cmd_ers_suspend),
        .cmd_resume       (cmd_resume),
        .stat             (sc)
    );

    fsp_erase_unit #(.NUM_SECT(NUM_SECT)) u_erase (
        .clk            (clk),
        .por_rst        (por_rst),
        .hw_rst         (hw_rst),
        .supply_low     (supply_low),
        .boot_top       (boot_top),
        .sec_mode       (sc.mode),
        .cmd_chip_erase (cmd_chip_erase),
        .erase_go       (erase_go),
        .erase_mask     (erase_mask)
    );

    assign pwd_mode      = lk.pwd;
    assign lock_bit      = lk.lock;
    assign unlock_err    = lk.err;
    assign ppb_wr_ok     = !lk.lock && !supply_low;
    assign sec_prot      = sc.prot;
    assign sec_mode      = sc.mode;
    assign sec_prog_ok   = sc.mode && !sc.prot && !supply_low;
    assign resume_grant  = sc.grant;
    assign resume_reject = sc.reject;
endmodule

// File: rtl/fsp_lock_ctrl_chk.sv
module fsp_lock_ctrl_chk #(
    parameter int NUM_SECT = 46
) (
    input logic                clk,
    input logic                por_rst,
    input logic                hw_rst,
    input logic                supply_low,
    input logic                cmd_pwd_unlock,
    input logic                pwd_match,
    input logic                cmd_resume,
    input logic                pwd_mode,
    input logic                lock_bit,
    input logic                sec_prot,
    input logic                sec_mode,
    input logic                resume_grant,
    input logic                erase_go,
    input logic [NUM_SECT-1:0] erase_mask
);
    AST_HWRST_LOCK_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (por_rst)
        hw_rst |=> lock_bit == pwd_mode); // R12

    AST_CLEAR_ONLY_BY_UNLOCK: assert property (@(posedge clk) disable iff (por_rst)
        (lock_bit && !hw_rst && !(cmd_pwd_unlock && pwd_match && pwd_mode && !supply_low))
        |=> lock_bit); // R2

    AST_PERSIST_STAYS_LOCKED: assert property (@(posedge clk) disable iff (por_rst)
        (!pwd_mode && lock_bit && !hw_rst) |=> lock_bit); // R5

    AST_SEC_PROT_STICKY: assert property (@(posedge clk) disable iff (por_rst)
        sec_prot |=> sec_prot); // R6

    AST_RESUME_BLOCKED_SECURED: assert property (@(posedge clk) disable iff (por_rst)
        (sec_mode && cmd_resume) |=> !resume_grant); // R8

    AST_ERASE_MASK_SHAPE: assert property (@(posedge clk) disable iff (por_rst)
        erase_go |-> ($countones(erase_mask) >= NUM_SECT - 1)); // R7

    AST_SUPPLY_LOW_QUIET: assert property (@(posedge clk) disable iff (por_rst)
        supply_low |=> (!sec_mode && !erase_go && !resume_grant)); // R9
endmodule

bind fsp_lock_ctrl fsp_lock_ctrl_chk #(.NUM_SECT(NUM_SECT)) u_chk (
    .clk            (clk),
    .por_rst        (por_rst),
    .hw_rst         (hw_rst),
    .supply_low     (supply_low),
    .cmd_pwd_unlock (cmd_pwd_unlock),
    .pwd_match      (pwd_match),
    .cmd_resume     (cmd_resume),
    .pwd_mode       (pwd_mode),
    .lock_bit       (lock_bit),
    .sec_prot       (sec_prot),
    .sec_mode       (sec_mode),
    .resume_grant   (resume_grant),
    .erase_go       (erase_go),
    .erase_mask     (erase_mask)
);

// File: tb/fsp_lock_ctrl_test.sv
module fsp_lock_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 46;

    logic clk = 1'b0;
    logic por_rst = 1'b1, hw_rst = 1'b0, supply_low = 1'b0;
    logic nv_pwd_mode_i = 1'b0, nv_sec_prot_i = 1'b0, boot_top = 1'b1;
    logic cmd_pwd_mode_set = 1'b0, cmd_sec_prot_set = 1'b0, cmd_lock_set = 1'b0;
    logic cmd_pwd_unlock = 1'b0, pwd_match = 1'b0;
    logic cmd_sec_entry = 1'b0, cmd_sec_exit = 1'b0;
    logic cmd_pgm_suspend = 1'b0, cmd_ers_suspend = 1'b0, cmd_resume = 1'b0;
    logic cmd_chip_erase = 1'b0;
    logic pwd_mode, lock_bit, ppb_wr_ok, unlock_err, sec_prot, sec_mode;
    logic sec_prog_ok, resume_grant, resume_reject, erase_go;
    logic [NS-1:0] erase_mask;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsp_lock_ctrl #(.NUM_SECT(NS)) uut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_cmds();
        por_rst = 0; hw_rst = 0; supply_low = 0;
        cmd_pwd_mode_set = 0; cmd_sec_prot_set = 0; cmd_lock_set = 0;
        cmd_pwd_unlock = 0; pwd_match = 0; cmd_sec_entry = 0; cmd_sec_exit = 0;
        cmd_pgm_suspend = 0; cmd_ers_suspend = 0; cmd_resume = 0; cmd_chip_erase = 0;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_por(input logic nv_pwd, input logic nv_prot);
        clear_cmds();
        nv_pwd_mode_i = nv_pwd; nv_sec_prot_i = nv_prot; por_rst = 1;
        step();
        clear_cmds();
    endtask

    task automatic pulse_cmd(ref logic sig);
        sig = 1; step(); sig = 0;
    endtask

    function automatic logic [NS-1:0] mask_without(input int idx);
        logic [NS-1:0] m = '1;
        if (idx >= 0) m[idx] = 1'b0;
        return m;
    endfunction

    task automatic t_persistent();
        do_por(0, 0);
        check("R4 por lock clear", lock_bit, 0);
        check("R4 ppb permit after por", ppb_wr_ok, 1);
        check("R4 pwd mode clear", pwd_mode, 0);
        pulse_cmd(cmd_lock_set);
        check("R4 lock set cmd", lock_bit, 1);
        cmd_pwd_unlock = 1; pwd_match = 1; step(); clear_cmds();
        check("R5 unlock ignored lock", lock_bit, 1);
        check("R5 unlock ignored err", unlock_err, 0);
        cmd_pwd_unlock = 1; pwd_match = 0; step(); clear_cmds();
        check("R5 bad unlock no err", unlock_err, 0);
        pulse_cmd(hw_rst);
        check("R4 hw reset clears lock", lock_bit, 0);
    endtask

    task automatic t_password();
        do_por(1, 0);
        check("R1 por sets lock", lock_bit, 1);
        check("R1 ppb blocked", ppb_wr_ok, 0);
        cmd_pwd_unlock = 1; pwd_match = 0; step(); clear_cmds();
        check("R10 failed unlock keeps lock", lock_bit, 1);
        check("R10 error pulse", unlock_err, 1);
        step();
        check("R10 error one cycle", unlock_err, 0);
        cmd_pwd_unlock = 1; pwd_match = 1; step(); clear_cmds();
        check("R2 good unlock clears", lock_bit, 0);
        check("R2 ppb permit", ppb_wr_ok, 1);
        check("R2 no error", unlock_err, 0);
        pulse_cmd(cmd_lock_set);
        check("R3 lock set again", lock_bit, 1);
        cmd_pwd_unlock = 1; pwd_match = 1; step(); clear_cmds();
        pulse_cmd(hw_rst);
        check("R1 hw reset sets lock", lock_bit, 1);
        // mode bit set by command in persistent mode, then reset
        do_por(0, 0);
        pulse_cmd(cmd_pwd_mode_set);
        check("R1 mode set keeps lock", lock_bit, 0);
        pulse_cmd(hw_rst);
        check("R1 new mode reset locks", lock_bit, 1);
    endtask

    task automatic t_priority();
        do_por(1, 0);
        hw_rst = 1; cmd_pwd_unlock = 1; pwd_match = 1; step(); clear_cmds();
        check("R12 hw reset beats unlock", lock_bit, 1);
        por_rst = 1; nv_pwd_mode_i = 0; nv_sec_prot_i = 0; cmd_lock_set = 1; step(); clear_cmds();
        check("R12 por beats lock set", lock_bit, 0);
    endtask

    task automatic t_secure();
        do_por(0, 0);
        pulse_cmd(cmd_sec_entry);
        check("R6 secured mode on", sec_mode, 1);
        check("R6 program allowed before protect", sec_prog_ok, 1);
        pulse_cmd(cmd_sec_exit);
        pulse_cmd(cmd_sec_prot_set);
        pulse_cmd(cmd_sec_entry);
        check("R6 program inhibited", sec_prog_ok, 0);
        pulse_cmd(hw_rst);
        check("R6 prot survives hw reset", sec_prot, 1);
        pulse_cmd(cmd_sec_entry);
        check("R6 still inhibited", sec_prog_ok, 0);
    endtask

    task automatic t_suspend();
        do_por(0, 0);
        pulse_cmd(cmd_ers_suspend);
        pulse_cmd(cmd_sec_entry);
        check("R8 entry during suspend", sec_mode, 1);
        pulse_cmd(cmd_resume);
        check("R8 resume rejected", resume_reject, 1);
        check("R8 no grant", resume_grant, 0);
        pulse_cmd(cmd_sec_exit);
        pulse_cmd(cmd_resume);
        check("R8 resume granted after exit", resume_grant, 1);
        check("R8 no reject after exit", resume_reject, 0);
    endtask

    task automatic t_erase();
        do_por(0, 0);
        boot_top = 1;
        pulse_cmd(cmd_chip_erase);
        check("R7 erase go", erase_go, 1);
        check("R7 full mask outside secured", erase_mask, mask_without(-1));
        step();
        check("R7 go one cycle", erase_go, 0);
        pulse_cmd(cmd_sec_entry);
        pulse_cmd(cmd_chip_erase);
        check("R7 erase allowed in secured", erase_go, 1);
        check("R11 top boot excludes 0", erase_mask, mask_without(0));
        boot_top = 0;
        pulse_cmd(cmd_chip_erase);
        check("R11 bottom boot excludes 45", erase_mask, mask_without(NS - 1));
    endtask

    task automatic t_supply();
        do_por(0, 0);
        pulse_cmd(cmd_pgm_suspend);
        pulse_cmd(cmd_sec_entry);
        supply_low = 1;
        cmd_lock_set = 1; cmd_chip_erase = 1; cmd_sec_prot_set = 1;
        step();
        check("R9 ppb permit off", ppb_wr_ok, 0);
        clear_cmds();
        supply_low = 1; cmd_resume = 1; cmd_pwd_mode_set = 1;
        step();
        clear_cmds();
        check("R9 lock unchanged", lock_bit, 0);
        check("R9 secured mode cleared", sec_mode, 0);
        check("R9 no erase", erase_go, 0);
        check("R9 no resume grant", resume_grant, 0);
        check("R9 prot not set", sec_prot, 0);
        check("R9 mode bit not set", pwd_mode, 0);
        pulse_cmd(cmd_resume);
        check("R9 suspension cleared", resume_grant, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        step();
        t_persistent();
        t_password();
        t_priority();
        t_secure();
        t_suspend();
        t_erase();
        t_supply();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule